// File: doc/BRIEF.md
# Soft-Start and Overcurrent Restart Sequencer

This block orders power-up and fault recovery for a switching regulator controller. The soft-start ramp is held as a digital level that counts up and down. An undervoltage-lockout status input keeps the sequencer at rest with the level cleared. Once the supply is good, the level climbs by a programmable charge step on every cycle until it reaches a full limit. While the level climbs and after it is full, the power stage may switch.

When the overcurrent flag fires, a fault latch forces the drivers off. A fault during the climb does not cut the ramp short. The level first keeps climbing to the full limit. It then falls by a larger, programmable discharge step until it is below a restart limit, and only then does a new climb begin. A fault that arrives at full level starts the fall at once. In either case, faults that keep coming back cannot retrigger faster than one complete soft-start period.

The states are LOCKOUT, CHARGE, RUN, FAULT_CHARGE and DISCHARGE. The named transitions are:
- supply-good (LOCKOUT to CHARGE)
- ramp-done (CHARGE to RUN)
- early-fault (CHARGE to FAULT_CHARGE)
- run-fault (RUN to DISCHARGE)
- fault-full (FAULT_CHARGE to DISCHARGE)
- restart (DISCHARGE to CHARGE)
- lockout, from any state to LOCKOUT.

Top module: `ssq_fault_sequencer`

## Requirements
- R1: While reset is low, and directly after reset, the state code is 0 (LOCKOUT), the level is 0, the fault latch is 0 and drive enable is 0.
- R2: When the lockout input is high at a clock edge, the next state is LOCKOUT (code 0) and the level becomes 0, whatever the state was. In LOCKOUT, drive enable and the fault latch are 0.
- R3: In LOCKOUT with the lockout input low, the next state is CHARGE (code 1). In CHARGE and FAULT_CHARGE, the level rises by the charge step on each edge, clamped at FULL_LVL.
- R4: In CHARGE, when the level is at or above FULL_LVL and overcurrent is low, the next state is RUN (code 2). The level holds in RUN. Drive enable is 1 only in CHARGE and RUN.
- R5: Overcurrent in CHARGE moves the block to FAULT_CHARGE (code 3), which sets the fault latch and clears drive enable. Charging continues until the level is at or above FULL_LVL, and then the state becomes DISCHARGE (code 4).
- R6: Overcurrent in RUN moves the block straight to DISCHARGE (code 4), with the fault latch set.
- R7: In DISCHARGE, the level falls by the discharge step on each edge, with a floor at 0. When the level is below RESTART_LVL, the next state is CHARGE and the fault latch clears.
- R8: Overcurrent in FAULT_CHARGE or DISCHARGE has no effect on the state, the level or the outputs.
- R9: When the lockout input and overcurrent are both high, lockout wins: the next state is LOCKOUT with the level at 0 and the fault latch at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uvlo_i | input | 1 | Undervoltage-lockout status; high means the supply is not good |
| oc_i | input | 1 | Overcurrent flag |
| charge_step_i | input | STEP_W | Amount added to the level per cycle while charging |
| dis_step_i | input | STEP_W | Amount subtracted from the level per cycle while discharging |
| level_o | output | LVL_W | Soft-start level |
| fault_latch_o | output | 1 | Fault latch; high forces the drivers low |
| drive_en_o | output | 1 | High when the drivers may switch |
| state_o | output | 3 | State code (0 LOCKOUT, 1 CHARGE, 2 RUN, 3 FAULT_CHARGE, 4 DISCHARGE) |

## Verification
The hardest state to reach is FAULT_CHARGE with the level partway up the ramp, especially when a second overcurrent or a lockout arrives before the level is full. A random pulse almost never lands there in the right order.

Directed sequences build these cases on purpose. One climbs a few steps, raises overcurrent, and then pulses it again during the rest of the climb and during the fall. Another asserts lockout and overcurrent together in the middle of a fall. A long random run then follows, with sparse overcurrent and lockout pulses and random step sizes. A cycle-accurate model in the bench predicts every output.

// File: rtl/ssq_pkg.sv
`timescale 1ns/1ps
package ssq_pkg;
    typedef enum logic [2:0] {
        SSQ_LOCKOUT      = 3'd0,
        SSQ_CHARGE       = 3'd1,
        SSQ_RUN          = 3'd2,
        SSQ_FAULT_CHARGE = 3'd3,
        SSQ_DISCHARGE    = 3'd4
    } ssq_state_e;
endpackage

// File: rtl/ssq_level_ctr.sv
`timescale 1ns/1ps
module ssq_level_ctr #(
    parameter int LVL_W       = 16,
    parameter int STEP_W      = 8,
    parameter int FULL_LVL    = 5000,
    parameter int RESTART_LVL = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              up_i,
    input  logic              down_i,
    input  logic [STEP_W-1:0] step_up_i,
    input  logic [STEP_W-1:0] step_dn_i,
    output logic [LVL_W-1:0]  level_o,
    output logic              full_o,
    output logic              low_o
);
    localparam logic [LVL_W-1:0] FULL_V    = LVL_W'(FULL_LVL);
    localparam logic [LVL_W-1:0] RESTART_V = LVL_W'(RESTART_LVL);

    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] level_d;
    logic [LVL_W:0]   sum;
    logic [LVL_W-1:0] dn_ext;

    assign sum    = {1'b0, level_q} + (LVL_W+1)'(step_up_i);
    assign dn_ext = LVL_W'(step_dn_i);

    always_comb begin
        level_d = level_q;
        if (clear_i) begin
            level_d = '0;
        end else if (up_i) begin
            if (sum > {1'b0, FULL_V}) level_d = FULL_V;
            else                      level_d = sum[LVL_W-1:0];
        end else if (down_i) begin
            if (level_q > dn_ext) level_d = level_q - dn_ext;
            else                  level_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign level_o = level_q;
    assign full_o  = (level_q >= FULL_V);
    assign low_o   = (level_q < RESTART_V);

    // R3
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL_V);

    // R2
    level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (level_q == '0));

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !up_i && !down_i) |=> $stable(level_q));
endmodule

// File: rtl/ssq_fsm.sv
`timescale 1ns/1ps
module ssq_fsm
    import ssq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo_i,
    input  logic       oc_i,
    input  logic       full_i,
    input  logic       low_i,
    output ssq_state_e state_o,
    output logic       clear_o,
    output logic       up_o,
    output logic       down_o,
    output logic       fault_latch_o,
    output logic       drive_en_o
);
    ssq_state_e state_q;
    ssq_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (uvlo_i) begin
            state_d = SSQ_LOCKOUT;
        end else begin
            unique case (state_q)
                SSQ_LOCKOUT:      state_d = SSQ_CHARGE;
                SSQ_CHARGE:       if (oc_i)        state_d = SSQ_FAULT_CHARGE;
                                  else if (full_i) state_d = SSQ_RUN;
                SSQ_RUN:          if (oc_i)        state_d = SSQ_DISCHARGE;
                SSQ_FAULT_CHARGE: if (full_i)      state_d = SSQ_DISCHARGE;
                SSQ_DISCHARGE:    if (low_i)       state_d = SSQ_CHARGE;
                default:          state_d = SSQ_LOCKOUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SSQ_LOCKOUT;
        else        state_q <= state_d;
    end

    always_comb begin
        clear_o       = uvlo_i;
        up_o          = 1'b0;
        down_o        = 1'b0;
        fault_latch_o = 1'b0;
        drive_en_o    = 1'b0;
        unique case (state_q)
            SSQ_LOCKOUT: ;
            SSQ_CHARGE: begin
                up_o       = 1'b1;
                drive_en_o = 1'b1;
            end
            SSQ_RUN:    drive_en_o = 1'b1;
            SSQ_FAULT_CHARGE: begin
                up_o          = 1'b1;
                fault_latch_o = 1'b1;
            end
            SSQ_DISCHARGE: begin
                down_o        = 1'b1;
                fault_latch_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R5
    latch_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latch_o |-> !drive_en_o);

    // R2
    lockout_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (state_q == SSQ_LOCKOUT));

    // R6
    run_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SSQ_RUN && oc_i && !uvlo_i) |=> (state_q == SSQ_DISCHARGE));

    // R8
    fault_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SSQ_FAULT_CHARGE && !uvlo_i) |=> fault_latch_o);

    // R7
    discharge_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SSQ_DISCHARGE && !low_i && !uvlo_i) |=> (state_q == SSQ_DISCHARGE));
endmodule

// File: rtl/ssq_fault_sequencer.sv
`timescale 1ns/1ps
module ssq_fault_sequencer
    import ssq_pkg::*;
#(
    parameter int LVL_W       = 16,
    parameter int STEP_W      = 8,
    parameter int FULL_LVL    = 5000,
    parameter int RESTART_LVL = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo_i,
    input  logic              oc_i,
    input  logic [STEP_W-1:0] charge_step_i,
    input  logic [STEP_W-1:0] dis_step_i,
    output logic [LVL_W-1:0]  level_o,
    output logic              fault_latch_o,
    output logic              drive_en_o,
    output logic [2:0]        state_o
);
    ssq_state_e st;
    logic clr, up, dn, full, low;

    ssq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .uvlo_i        (uvlo_i),
        .oc_i          (oc_i),
        .full_i        (full),
        .low_i         (low),
        .state_o       (st),
        .clear_o       (clr),
        .up_o          (up),
        .down_o        (dn),
        .fault_latch_o (fault_latch_o),
        .drive_en_o    (drive_en_o)
    );

    ssq_level_ctr #(
        .LVL_W       (LVL_W),
        .STEP_W      (STEP_W),
        .FULL_LVL    (FULL_LVL),
        .RESTART_LVL (RESTART_LVL)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clr),
        .up_i      (up),
        .down_i    (dn),
        .step_up_i (charge_step_i),
        .step_dn_i (dis_step_i),
        .level_o   (level_o),
        .full_o    (full),
        .low_o     (low)
    );

    assign state_o = st;

    // R9
    lockout_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_i && oc_i) |=> (!fault_latch_o && level_o == '0));
endmodule

// File: tb/ssq_fault_sequencer_tb.sv
`timescale 1ns/1ps
module ssq_fault_sequencer_tb_top;
    localparam int LVL_W = 16;
    localparam int STEP_W = 8;
    localparam int FULL = 1000;
    localparam int RST_L = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 1'b1;
    logic oc = 1'b0;
    logic [STEP_W-1:0] cstep = 8'd100;
    logic [STEP_W-1:0] dstep = 8'd200;
    logic [LVL_W-1:0] level;
    logic latch, drive;
    logic [2:0] state;

    int checks = 0;
    int fails = 0;
    int m_st = 0;
    int m_lvl = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ssq_fault_sequencer #(
        .LVL_W(LVL_W), .STEP_W(STEP_W), .FULL_LVL(FULL), .RESTART_LVL(RST_L)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .oc_i(oc),
        .charge_step_i(cstep), .dis_step_i(dstep),
        .level_o(level), .fault_latch_o(latch), .drive_en_o(drive), .state_o(state)
    );

    function automatic int f_state(int st, int lvl, bit u, bit o);
        if (u) return 0;
        case (st)
            0: return 1;
            1: return o ? 3 : (lvl >= FULL ? 2 : 1);
            2: return o ? 4 : 2;
            3: return (lvl >= FULL) ? 4 : 3;
            4: return (lvl < RST_L) ? 1 : 4;
            default: return 0;
        endcase
    endfunction

    function automatic int f_level(int st, int lvl, bit u, int cs, int ds);
        if (u) return 0;
        if (st == 1 || st == 3) return (lvl + cs > FULL) ? FULL : lvl + cs;
        if (st == 4) return (lvl > ds) ? lvl - ds : 0;
        return lvl;
    endfunction

    task automatic compare(input string tag);
        bit el, ed;
        el = (m_st == 3 || m_st == 4);
        ed = (m_st == 1 || m_st == 2);
        checks++;
        if (int'(state) != m_st || int'(level) != m_lvl || latch != el || drive != ed) begin
            fails++;
            $display("FAIL %s: state=%0d level=%0d latch=%0b drive=%0b expected state=%0d level=%0d latch=%0b drive=%0b",
                     tag, state, level, latch, drive, m_st, m_lvl, el, ed);
        end
    endtask

    task automatic cyc(input bit u, input bit o, input int cs, input int ds);
        string tag;
        if (u && o)                         tag = "R9";
        else if (u)                         tag = "R2";
        else if (o && (m_st == 3 || m_st == 4)) tag = "R8";
        else if (o && m_st == 2)            tag = "R6";
        else if (o && m_st == 1)            tag = "R5";
        else if (m_st == 0)                 tag = "R3";
        else if (m_st == 1)                 tag = (m_lvl >= FULL) ? "R4" : "R3";
        else if (m_st == 2)                 tag = "R4";
        else if (m_st == 3)                 tag = "R5";
        else                                tag = "R7";
        uvlo = u; oc = o; cstep = cs[STEP_W-1:0]; dstep = ds[STEP_W-1:0];
        m_lvl = f_level(m_st, m_lvl, u, cs, ds);
        m_st  = f_state(m_st, m_lvl == 0 && u ? 0 : m_lvl, u, o);
        @(negedge clk);
        compare(tag);
    endtask

    // next state must use the level before the edge, so compute in order
    task automatic step(input bit u, input bit o, input int cs, input int ds);
        int ns, nl;
        string tag;
        if (u && o)                             tag = "R9";
        else if (u)                             tag = "R2";
        else if (o && (m_st == 3 || m_st == 4)) tag = "R8";
        else if (o && m_st == 2)                tag = "R6";
        else if (o && m_st == 1)                tag = "R5";
        else if (m_st == 1 || m_st == 0)        tag = (m_lvl >= FULL) ? "R4" : "R3";
        else if (m_st == 2)                     tag = "R4";
        else if (m_st == 3)                     tag = "R5";
        else                                    tag = "R7";
        uvlo = u; oc = o; cstep = cs[STEP_W-1:0]; dstep = ds[STEP_W-1:0];
        ns = f_state(m_st, m_lvl, u, o);
        nl = f_level(m_st, m_lvl, u, cs, ds);
        m_st = ns; m_lvl = nl;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run_until(input int target, input int cs, input int ds);
        for (int k = 0; k < 2000 && m_st != target; k++) step(1'b0, 1'b0, cs, ds);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        step(1'b1, 1'b0, 100, 200);
        // climb to RUN, fault in RUN, overcurrent pulses while falling
        run_until(2, 100, 200);
        step(1'b0, 1'b0, 100, 200);
        step(1'b0, 1'b1, 100, 200);
        step(1'b0, 1'b1, 100, 200);
        step(1'b0, 1'b0, 100, 200);
        step(1'b0, 1'b1, 100, 200);
        run_until(1, 100, 200);
        // early fault partway up the ramp, repeated pulses during climb
        step(1'b0, 1'b0, 60, 150);
        step(1'b0, 1'b1, 60, 150);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 60, 150);
        run_until(4, 60, 150);
        step(1'b0, 1'b1, 60, 150);
        run_until(1, 60, 150);
        // lockout together with overcurrent during a fall
        run_until(2, 255, 90);
        step(1'b0, 1'b1, 255, 90);
        step(1'b0, 1'b0, 255, 90);
        step(1'b1, 1'b1, 255, 90);
        step(1'b0, 1'b0, 255, 90);
        // small steps: floor at zero with a discharge step larger than the level
        run_until(2, 7, 255);
        step(1'b0, 1'b1, 7, 255);
        run_until(1, 7, 255);
        // random phase
        for (int k = 0; k < 30000; k++) begin
            bit u, o;
            u = ($urandom % 300) == 0;
            o = ($urandom % 50) == 0;
            step(u, o, 1 + int'($urandom % 255), 1 + int'($urandom % 255));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule